// File: doc/BRIEF.md
# NAND Status-Polling Ready Waiter

This block lets a raw NAND flash controller wait for the end of an array operation without a ready/busy pin. When a request arrives, it selects the device and writes the status-read opcode with the command latch enable high. It then waits through fixed idle gaps, arms a cycle-budget timer and reads status bytes one after another until bit 6 of a byte shows the device is ready.

On success it pulses `done_o` and returns the last status byte. On a read flow the caller can also ask for a trailing read opcode, which takes the device out of status mode so that page data can be streamed next. A program flow leaves that opcode out. If the budget runs out before the device is ready, the block pulses `timeout_o`, sends nothing more and releases the chip select. Page transfer, error correction and timing calibration belong to other blocks.

Top module: `nand_rdy_poller`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, the outputs hold their idle values: CE# = 1, CLE = 0, WE# = 1, RE# = 1, data output enable = 0, busy = 0, done = 0, timeout = 0.
- R2: A start pulse is accepted only when the block is idle. `busy_o` rises in the cycle after the accepted start and stays high until the cycle in which `done_o` or `timeout_o` pulses; in that cycle it is already low. A start pulse seen while busy has no effect: no extra opcode, no extra done pulse, and busy does not rise again afterwards.
- R3: Every opcode is written with CE# low and with CLE and the data output enable high. The opcode is on the bus for one cycle before WE# falls, WE# stays low for exactly WE_LOW_CYC cycles, and the opcode is still driven for one cycle after WE# rises. The status opcode is 0x70.
- R4: The first status read starts (RE# falls) exactly POST_CMD_IDLE + POST_ARM_IDLE + 4 clock cycles after WE# rises for the status opcode. With the default values this is 11 cycles.
- R5: Each status read holds RE# low for exactly RE_LOW_CYC cycles. The byte on `nand_dq_i` is captured at the clock edge where RE# returns high. Reads repeat with no opcode between them until a captured byte has bit 6 = 1.
- R6: When a ready byte is captured, the request ends with a single one-cycle `done_o` pulse. The number of status reads is the number of not-ready bytes plus one, and `status_o` shows the ready byte while `done_o` is high.
- R7: If `exit_read_i` was 1 at the accepted start, the block writes opcode 0x00 after the ready byte and before `done_o`, framed as in R3. If `exit_read_i` was 0, the status opcode is the only opcode of the request.
- R8: The budget counter starts when the wait is armed and is tested only after a not-ready byte. If `budget_i` cycles (latched at start) have elapsed, the request ends with a one-cycle `timeout_o` pulse, no `done_o` and no 0x00 opcode. A budget of 0 times out after the first not-ready byte. A ready byte always wins, even when the budget is already used up.
- R9: CE# is low whenever `busy_o` is high, and CLE is never high while RE# is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request pulse; ignored while busy |
| exit_read_i | input | 1 | Send the trailing 0x00 opcode after ready (read flows) |
| budget_i | input | BUDGET_W | Maximum wait in clock cycles, latched at start |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle pulse: device ready, sequence complete |
| timeout_o | output | 1 | One-cycle pulse: budget expired before ready |
| status_o | output | 8 | Last status byte read from the device |
| nand_ce_n_o | output | 1 | Chip enable, active low |
| nand_cle_o | output | 1 | Command latch enable |
| nand_we_n_o | output | 1 | Write enable, active low |
| nand_re_n_o | output | 1 | Read enable, active low |
| nand_dq_o | output | 8 | Data bus output |
| nand_dq_oe_o | output | 1 | Data bus output enable |
| nand_dq_i | input | 8 | Data bus input |

## Verification
A wrong control state shows up on the NAND pins within a few cycles, not only at the end of the request:
- A miscounted idle gap moves the first RE# falling edge away from its fixed 11-cycle offset.
- A wrong strobe counter changes the measured WE# or RE# low widths.
- Sampling at the wrong moment reads the idle bus (0x00) instead of the status byte. Bit 6 then never appears, so the request ends in a timeout instead of done.

Mistakes in the ending path show up at the end of each request:
- A lost exit flag shows as a missing or extra 0x00 opcode in the captured opcode log.
- A wrong budget comparison turns a zero-budget request into a done, or the reverse.

// File: rtl/nrp_pkg.sv
package nrp_pkg;
  localparam logic [7:0] OP_STATUS = 8'h70;
  localparam logic [7:0] OP_READ0  = 8'h00;
  localparam int         RDY_BIT   = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMDWAIT,
    ST_GAP_CMD,
    ST_ARM,
    ST_GAP_ARM,
    ST_POLL,
    ST_EXITWAIT
  } ctl_state_e;
endpackage

// File: rtl/nrp_cmd_wr.sv
// Writes one opcode: CLE and data are driven for one cycle before WE# falls
// and for one cycle after it rises.
module nrp_cmd_wr #(
  parameter int WE_LOW_CYC = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go_i,
  input  logic [7:0] op_i,
  output logic       cle_o,
  output logic       we_n_o,
  output logic [7:0] dq_o,
  output logic       oe_o,
  output logic       done_o
);
  localparam int CW = $clog2(WE_LOW_CYC + 1);

  typedef enum logic [1:0] {W_IDLE, W_SETUP, W_LOW, W_HOLD} wr_ph_e;

  wr_ph_e        ph_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= W_IDLE;
      cnt_q  <= '0;
      cle_o  <= 1'b0;
      we_n_o <= 1'b1;
      dq_o   <= '0;
      oe_o   <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (ph_q)
        W_IDLE: if (go_i) begin
          cle_o <= 1'b1;
          oe_o  <= 1'b1;
          dq_o  <= op_i;
          ph_q  <= W_SETUP;
        end
        W_SETUP: begin
          we_n_o <= 1'b0;
          cnt_q  <= '0;
          ph_q   <= W_LOW;
        end
        W_LOW: if (cnt_q == CW'(WE_LOW_CYC - 1)) begin
          we_n_o <= 1'b1;
          ph_q   <= W_HOLD;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
        W_HOLD: begin
          cle_o  <= 1'b0;
          oe_o   <= 1'b0;
          done_o <= 1'b1;
          ph_q   <= W_IDLE;
        end
        default: ph_q <= W_IDLE;
      endcase
    end
  end

  AST_WE_SETUP: assert property (@(posedge clk) disable iff (rst)
    $fell(we_n_o) |-> $past(oe_o) && $past(cle_o)); // R3
  AST_WE_HOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n_o) |-> cle_o && oe_o); // R3
  AST_DQ_STABLE_WE: assert property (@(posedge clk) disable iff (rst)
    !we_n_o |-> $stable(dq_o) && oe_o); // R3
endmodule

// File: rtl/nrp_stat_rd.sv
// Reads one status byte: RE# is low for RE_LOW_CYC cycles and the byte is
// captured at the edge where RE# returns high.
module nrp_stat_rd #(
  parameter int RE_LOW_CYC = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go_i,
  input  logic [7:0] dq_i,
  output logic       re_n_o,
  output logic [7:0] byte_o,
  output logic       done_o
);
  localparam int CW = $clog2(RE_LOW_CYC + 1);

  typedef enum logic [1:0] {R_IDLE, R_LOW, R_REC} rd_ph_e;

  rd_ph_e        ph_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= R_IDLE;
      cnt_q  <= '0;
      re_n_o <= 1'b1;
      byte_o <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (ph_q)
        R_IDLE: if (go_i) begin
          re_n_o <= 1'b0;
          cnt_q  <= '0;
          ph_q   <= R_LOW;
        end
        R_LOW: if (cnt_q == CW'(RE_LOW_CYC - 1)) begin
          re_n_o <= 1'b1;
          byte_o <= dq_i;
          ph_q   <= R_REC;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
        R_REC: begin
          done_o <= 1'b1;
          ph_q   <= R_IDLE;
        end
        default: ph_q <= R_IDLE;
      endcase
    end
  end

  AST_RD_DONE_RE_HIGH: assert property (@(posedge clk) disable iff (rst)
    done_o |-> re_n_o && $past(re_n_o)); // R5
  AST_BYTE_ONLY_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    !$rose(re_n_o) |-> $stable(byte_o)); // R5
endmodule

// File: rtl/nrp_budget.sv
// Counts the cycles of the wait from the moment it is armed; the expired
// flag stays set until the next load.
module nrp_budget #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic         run_i,
  input  logic [W-1:0] limit_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] lim_q;
  logic [W-1:0] cnt_nx;

  assign cnt_nx = cnt_q + W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      lim_q     <= '0;
      expired_o <= 1'b0;
    end else if (load_i) begin
      cnt_q     <= '0;
      lim_q     <= limit_i;
      expired_o <= (limit_i == '0);
    end else if (run_i && !expired_o) begin
      cnt_q     <= cnt_nx;
      expired_o <= (cnt_nx == lim_q);
    end
  end

  AST_EXPIRED_STICKY: assert property (@(posedge clk) disable iff (rst)
    expired_o && !load_i |=> expired_o); // R8
  AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    !load_i && !expired_o |=> cnt_q <= lim_q); // R8
endmodule

// File: rtl/nand_rdy_poller.sv
module nand_rdy_poller
  import nrp_pkg::*;
#(
  parameter int BUDGET_W      = 20,
  parameter int WE_LOW_CYC    = 2,
  parameter int RE_LOW_CYC    = 3,
  parameter int POST_CMD_IDLE = 5,  // at least 1
  parameter int POST_ARM_IDLE = 2   // at least 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                exit_read_i,
  input  logic [BUDGET_W-1:0] budget_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                timeout_o,
  output logic [7:0]          status_o,
  output logic                nand_ce_n_o,
  output logic                nand_cle_o,
  output logic                nand_we_n_o,
  output logic                nand_re_n_o,
  output logic [7:0]          nand_dq_o,
  output logic                nand_dq_oe_o,
  input  logic [7:0]          nand_dq_i
);
  localparam int GAP_MAX = (POST_CMD_IDLE > POST_ARM_IDLE) ? POST_CMD_IDLE : POST_ARM_IDLE;
  localparam int GAP_W   = $clog2(GAP_MAX + 1);

  ctl_state_e          st_q;
  logic [GAP_W-1:0]    gap_q;
  logic                busy_q, ce_n_q, done_q, tmo_q, exit_q;
  logic [BUDGET_W-1:0] bud_q;
  logic                wr_go_q, rd_go_q, tm_load_q;
  logic [7:0]          wr_op_q;
  logic                wr_done, rd_done, tm_exp, tm_run;
  logic [7:0]          rd_byte;

  assign tm_run = (st_q == ST_GAP_ARM) || (st_q == ST_POLL);

  nrp_cmd_wr #(.WE_LOW_CYC(WE_LOW_CYC)) u_wr (
    .clk    (clk),
    .rst    (rst),
    .go_i   (wr_go_q),
    .op_i   (wr_op_q),
    .cle_o  (nand_cle_o),
    .we_n_o (nand_we_n_o),
    .dq_o   (nand_dq_o),
    .oe_o   (nand_dq_oe_o),
    .done_o (wr_done)
  );

  nrp_stat_rd #(.RE_LOW_CYC(RE_LOW_CYC)) u_rd (
    .clk    (clk),
    .rst    (rst),
    .go_i   (rd_go_q),
    .dq_i   (nand_dq_i),
    .re_n_o (nand_re_n_o),
    .byte_o (rd_byte),
    .done_o (rd_done)
  );

  nrp_budget #(.W(BUDGET_W)) u_tm (
    .clk       (clk),
    .rst       (rst),
    .load_i    (tm_load_q),
    .run_i     (tm_run),
    .limit_i   (bud_q),
    .expired_o (tm_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      gap_q     <= '0;
      busy_q    <= 1'b0;
      ce_n_q    <= 1'b1;
      done_q    <= 1'b0;
      tmo_q     <= 1'b0;
      exit_q    <= 1'b0;
      bud_q     <= '0;
      wr_go_q   <= 1'b0;
      wr_op_q   <= OP_STATUS;
      rd_go_q   <= 1'b0;
      tm_load_q <= 1'b0;
    end else begin
      done_q    <= 1'b0;
      tmo_q     <= 1'b0;
      wr_go_q   <= 1'b0;
      rd_go_q   <= 1'b0;
      tm_load_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          busy_q  <= 1'b1;
          ce_n_q  <= 1'b0;
          exit_q  <= exit_read_i;
          bud_q   <= budget_i;
          wr_op_q <= OP_STATUS;
          wr_go_q <= 1'b1;
          st_q    <= ST_CMDWAIT;
        end
        ST_CMDWAIT: if (wr_done) begin
          gap_q <= '0;
          st_q  <= ST_GAP_CMD;
        end
        ST_GAP_CMD: if (gap_q == GAP_W'(POST_CMD_IDLE - 1)) begin
          st_q <= ST_ARM;
        end else begin
          gap_q <= gap_q + GAP_W'(1);
        end
        ST_ARM: begin
          tm_load_q <= 1'b1;
          gap_q     <= '0;
          st_q      <= ST_GAP_ARM;
        end
        ST_GAP_ARM: if (gap_q == GAP_W'(POST_ARM_IDLE - 1)) begin
          rd_go_q <= 1'b1;
          st_q    <= ST_POLL;
        end else begin
          gap_q <= gap_q + GAP_W'(1);
        end
        ST_POLL: if (rd_done) begin
          if (rd_byte[RDY_BIT]) begin
            if (exit_q) begin
              wr_op_q <= OP_READ0;
              wr_go_q <= 1'b1;
              st_q    <= ST_EXITWAIT;
            end else begin
              busy_q <= 1'b0;
              ce_n_q <= 1'b1;
              done_q <= 1'b1;
              st_q   <= ST_IDLE;
            end
          end else if (tm_exp) begin
            busy_q <= 1'b0;
            ce_n_q <= 1'b1;
            tmo_q  <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            rd_go_q <= 1'b1;
          end
        end
        ST_EXITWAIT: if (wr_done) begin
          busy_q <= 1'b0;
          ce_n_q <= 1'b1;
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign timeout_o   = tmo_q;
  assign status_o    = rd_byte;
  assign nand_ce_n_o = ce_n_q;

  AST_BUSY_CE_LOW: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !nand_ce_n_o); // R9
  AST_CLE_NOT_WITH_RE: assert property (@(posedge clk) disable iff (rst)
    nand_cle_o |-> nand_re_n_o); // R9
  AST_END_DROPS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (done_o || timeout_o) |-> !busy_o && $past(busy_o)); // R2
  AST_DONE_TMO_EXCL: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !timeout_o); // R6
  AST_TMO_NEEDS_EXPIRY: assert property (@(posedge clk) disable iff (rst)
    timeout_o |-> $past(tm_exp) && !$past(rd_byte[RDY_BIT])); // R8
  AST_DONE_AFTER_READY: assert property (@(posedge clk) disable iff (rst)
    done_o |-> status_o[RDY_BIT]); // R6
  AST_OPCODE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
    !nand_we_n_o |-> !nand_ce_n_o); // R3
endmodule

// File: tb/nand_rdy_poller_tb.sv
`timescale 1ns/1ps
module nand_rdy_poller_tb_top;
  localparam int BW  = 20;
  localparam int WEL = 2;
  localparam int REL = 3;
  localparam int PCI = 5;
  localparam int PAI = 2;
  localparam int GAP_EXP = PCI + PAI + 4;

  // vector: [29] exit, [28:21] busy reads before ready, [20:1] budget, [0] expect done
  localparam int NV = 7;
  localparam logic [29:0] VEC [NV] = '{
    {1'b1, 8'd0,   20'd1000, 1'b1},
    {1'b0, 8'd0,   20'd1000, 1'b1},
    {1'b1, 8'd4,   20'd1000, 1'b1},
    {1'b0, 8'd7,   20'd5000, 1'b1},
    {1'b1, 8'd255, 20'd0,    1'b0},
    {1'b1, 8'd255, 20'd60,   1'b0},
    {1'b1, 8'd0,   20'd0,    1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic exit_rd = 1'b0;
  logic [BW-1:0] budget = '0;
  logic busy_o, done_o, timeout_o;
  logic [7:0] status_o;
  logic ce_n, cle, we_n, re_n, dq_oe;
  logic [7:0] dq_o, dq_i;

  always #10 clk = ~clk;

  nand_rdy_poller #(
    .BUDGET_W(BW), .WE_LOW_CYC(WEL), .RE_LOW_CYC(REL),
    .POST_CMD_IDLE(PCI), .POST_ARM_IDLE(PAI)
  ) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .exit_read_i(exit_rd), .budget_i(budget),
    .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o), .status_o(status_o),
    .nand_ce_n_o(ce_n), .nand_cle_o(cle), .nand_we_n_o(we_n), .nand_re_n_o(re_n),
    .nand_dq_o(dq_o), .nand_dq_oe_o(dq_oe), .nand_dq_i(dq_i)
  );

  // device model: busy reads return 0xA0 (bit 6 clear), then 0xE0
  int polls_total = 0;
  int poll_base = 0;
  int rdy_after = 0;
  always @(posedge re_n) if (ce_n === 1'b0) polls_total++;
  assign dq_i = (re_n === 1'b0 && ce_n === 1'b0) ?
                (((polls_total - poll_base) >= rdy_after) ? 8'hE0 : 8'hA0) : 8'h00;

  // pin monitor, sampled at negedge
  int cyc = 0;
  int op_total = 0;
  logic [7:0] op_log [64];
  int done_total = 0, tmo_total = 0;
  int setup_bad = 0, we_len_bad = 0, re_len_bad = 0, excl_bad = 0, hold_bad = 0;
  int we_len = 0, re_len = 0;
  int st_rise_cyc = 0, first_re_cyc = -1;
  logic p_we = 1'b1, p_re = 1'b1, p_cle = 1'b0, p_oe = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (done_o) done_total++;
      if (timeout_o) tmo_total++;
      if (cle && !re_n) excl_bad++;
      if (p_we && !we_n && !(p_cle && p_oe)) setup_bad++;
      if (!we_n) we_len++;
      if (!p_we && we_n) begin
        if (we_len != WEL) we_len_bad++;
        if (!(cle && dq_oe && !ce_n)) hold_bad++;
        op_log[op_total % 64] = dq_o;
        op_total++;
        if (dq_o == 8'h70) begin
          st_rise_cyc  = cyc;
          first_re_cyc = -1;
        end
        we_len = 0;
      end
      if (p_re && !re_n && first_re_cyc < 0) first_re_cyc = cyc;
      if (!re_n) re_len++;
      if (!p_re && re_n) begin
        if (re_len != REL) re_len_bad++;
        re_len = 0;
      end
    end
    p_we = we_n; p_re = re_n; p_cle = cle; p_oe = dq_oe;
  end

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  int r_done, r_tmo, r_poll, r_ops, r_gap, r_op0, r_op1;
  logic [7:0] r_stat;
  bit r_busy_start, r_busy_end, r_ce_end;

  task automatic run_req(input bit ex, input int rdy, input int bud, input bit poke);
    int d0, t0, o0;
    @(negedge clk);
    rdy_after = rdy;
    poll_base = polls_total;
    d0 = done_total; t0 = tmo_total; o0 = op_total;
    start = 1'b1; exit_rd = ex; budget = BW'(bud);
    @(negedge clk);
    start = 1'b0;
    r_busy_start = busy_o;
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1; exit_rd = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 20000; i++) begin
      if (done_o || timeout_o) break;
      @(negedge clk);
    end
    r_stat = status_o; r_busy_end = busy_o; r_ce_end = ce_n;
    repeat (3) @(negedge clk);
    r_done = done_total - d0;
    r_tmo  = tmo_total - t0;
    r_ops  = op_total - o0;
    r_poll = polls_total - poll_base;
    r_gap  = first_re_cyc - st_rise_cyc;
    r_op0  = int'(op_log[o0 % 64]);
    r_op1  = (r_ops > 1) ? int'(op_log[(o0 + 1) % 64]) : -1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R2 watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ce_n && !cle && we_n && re_n && !dq_oe, "R1", "pins in reset", {ce_n, cle, we_n, re_n, dq_oe}, 5'b10110);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy_o && !done_o && !timeout_o, "R1", "flags after reset", {busy_o, done_o, timeout_o}, 0);
    chk(ce_n && we_n && re_n && !cle && !dq_oe, "R1", "pins after reset", {ce_n, cle, we_n, re_n, dq_oe}, 5'b10110);

    for (int v = 0; v < NV; v++) begin
      logic [29:0] e;
      int exp_poll;
      e = VEC[v];
      run_req(e[29], int'(e[28:21]), int'(e[20:1]), 1'b0);
      chk(r_busy_start, "R2", $sformatf("busy after start v%0d", v), r_busy_start, 1);
      chk(!r_busy_end && r_ce_end, "R2", $sformatf("busy/ce at end v%0d", v), r_busy_end, 0);
      chk(r_op0 == 8'h70, "R3", $sformatf("first opcode v%0d", v), r_op0, 8'h70);
      chk(r_gap == GAP_EXP, "R4", $sformatf("cmd-to-read gap v%0d", v), r_gap, GAP_EXP);
      if (e[0]) begin
        exp_poll = int'(e[28:21]) + 1;
        chk(r_done == 1 && r_tmo == 0, "R6", $sformatf("done pulse v%0d", v), r_done, 1);
        chk(r_poll == exp_poll, "R6", $sformatf("read count v%0d", v), r_poll, exp_poll);
        chk(r_stat == 8'hE0, "R6", $sformatf("status byte v%0d", v), r_stat, 8'hE0);
        if (e[29]) begin
          chk(r_ops == 2 && r_op1 == 0, "R7", $sformatf("exit opcode v%0d", v), r_op1, 0);
        end else begin
          chk(r_ops == 1, "R7", $sformatf("no exit opcode v%0d", v), r_ops, 1);
        end
      end else begin
        chk(r_tmo == 1 && r_done == 0, "R8", $sformatf("timeout pulse v%0d", v), r_tmo, 1);
        chk(r_ops == 1, "R8", $sformatf("no exit after timeout v%0d", v), r_ops, 1);
        if (e[20:1] == 0) chk(r_poll == 1, "R8", "zero budget single read", r_poll, 1);
        else              chk(r_poll >= 1, "R8", "reads before timeout", r_poll, 1);
      end
    end

    // R2: start while busy is ignored
    run_req(1'b0, 3, 1000, 1'b1);
    chk(r_done == 1, "R2", "single done with busy start", r_done, 1);
    chk(r_ops == 1, "R2", "no opcode from busy start", r_ops, 1);
    chk(r_poll == 4, "R2", "reads unchanged by busy start", r_poll, 4);
    repeat (20) @(negedge clk);
    chk(!busy_o && ce_n, "R2", "stays idle after ignored start", busy_o, 0);

    chk(setup_bad == 0, "R3", "WE# setup violations", setup_bad, 0);
    chk(hold_bad == 0, "R3", "WE# hold violations", hold_bad, 0);
    chk(we_len_bad == 0, "R3", "WE# low width errors", we_len_bad, 0);
    chk(re_len_bad == 0, "R5", "RE# low width errors", re_len_bad, 0);
    chk(excl_bad == 0, "R9", "CLE high while RE# low", excl_bad, 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule